// File: doc/BRIEF.md
# Single-Precision Floating-Point Subtractor

This unit computes x − y for two IEEE 754 binary32 operands. It returns a binary32 result and four exception flags: invalid, overflow, underflow and inexact. Each operand is first sorted into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. A fixed table indexed by the pair of classes settles every case that involves a NaN, an infinity or a zero. Only finite nonzero pairs reach the arithmetic path. That path turns the subtraction into an addition by inverting y's sign. It aligns the smaller operand with guard, round and sticky bits, adds or subtracts the magnitudes, normalises, and then rounds according to a 2-bit mode input.

The datapath is combinational. A parameter selects whether the result and flags are registered on the `in_valid` strobe, giving one cycle of latency, or passed straight through. The widths of the exponent and fraction fields are parameters, with binary32 as the default.

Top module: `fp_sub_unit`

## Requirements
- R1: If x is a signalling NaN (exponent all ones, fraction MSB 0, fraction nonzero), the result is x with fraction bit 22 set, sign and other payload kept, and only invalid raised. This holds whatever y is, including when y is also a signalling NaN.
- R2: If y is a signalling NaN and x is not, the result is y with fraction bit 22 set and only invalid raised. This holds even when x is a quiet NaN.
- R3: With no signalling NaN present, a quiet NaN x is returned unchanged. Otherwise a quiet NaN y is returned unchanged. No flag is raised in either case.
- R4: Infinity minus infinity with equal signs gives 0x7FC00000 and raises invalid. With unequal signs it returns x and raises no flag.
- R5: A zero or finite x minus an infinite y gives an infinity whose sign is the inverse of y's sign. An infinite x minus a zero or finite y gives x. Neither case raises a flag.
- R6: Zero minus zero with unequal signs returns x. With equal signs it returns +0, or −0 when the rounding mode is 11.
- R7: A zero x minus a nonzero finite y returns y with its sign bit inverted. A nonzero finite x minus a zero y returns x. Both cases are exact.
- R8: For finite nonzero operands, a result that is representable is returned exactly, with the sign of the operand of larger magnitude and no flag. Denormal inputs are handled, and a carry out of the magnitude sum renormalises.
- R9: An exact zero difference of nonzero operands gives −0 when the rounding mode is 11 and +0 otherwise.
- R10: The rounding mode encodes 00 as nearest-even, 01 as toward zero, 10 as toward +∞ and 11 as toward −∞. Any nonzero discarded bit raises inexact. A rounding carry renormalises the result.
- R11: When the rounded exponent reaches all ones, overflow and inexact are raised. The result is infinity under nearest-even, under toward +∞ with a positive sign, and under toward −∞ with a negative sign. In every other case it is the largest finite value of that sign.
- R12: A result below the smallest normal is produced as a denormal. Underflow is raised only when such a result is also inexact.
- R13: With registering enabled, the result and flags appear in the cycle after `in_valid` and `out_valid` pulses for that cycle. Without a strobe the outputs hold. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_x | input | 32 | Minuend, binary32 |
| op_y | input | 32 | Subtrahend, binary32 |
| rnd_mode | input | 2 | Rounding mode (00 RNE, 01 RTZ, 10 RUP, 11 RDN) |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Difference, binary32 |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Overflow |
| flag_underflow | output | 1 | Underflow |
| flag_inexact | output | 1 | Inexact |

## Verification
The assertions assume that `op_x`, `op_y` and `rnd_mode` are stable and known whenever `in_valid` is high. They also assume that `in_valid` is only ever 0 or 1. The quiet-NaN pass-through check looks at the operand ports in the cycle of the strobe, so the stimulus changes operands only on the falling edge. It raises `in_valid` for exactly one cycle per operation. Idle cycles deliberately carry changed operand values, which shows that only the strobe loads new results.

// File: rtl/fp_sub_pkg.sv
package fp_sub_pkg;

   typedef enum logic [2:0] {
      CL_ZERO  = 3'd0,
      CL_DENORM = 3'd1,
      CL_NORMAL = 3'd2,
      CL_INF   = 3'd3,
      CL_QNAN  = 3'd4,
      CL_SNAN  = 3'd5
   } fp_class_e;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_ZERO    = 2'b01,
      RM_UP      = 2'b10,
      RM_DOWN    = 2'b11
   } rnd_mode_e;

   typedef struct packed {
      logic invalid;
      logic overflow;
      logic underflow;
      logic inexact;
   } fp_flags_t;

endpackage

// File: rtl/fp_sub_classify.sv
module fp_sub_classify
   import fp_sub_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] word,
   output fp_class_e         cls
);
   logic [EXP_W-1:0]  ex;
   logic [FRAC_W-1:0] fr;

   assign ex = word[FRAC_W +: EXP_W];
   assign fr = word[FRAC_W-1:0];

   always_comb begin
      if (ex == '0)
         cls = (fr == '0) ? CL_ZERO : CL_DENORM;
      else if (ex == '1) begin
         if (fr == '0)
            cls = CL_INF;
         else
            cls = fr[FRAC_W-1] ? CL_QNAN : CL_SNAN;
      end else
         cls = CL_NORMAL;
   end
endmodule

// File: rtl/fp_sub_special.sv
module fp_sub_special
   import fp_sub_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] x,
   input  logic [WORD_W-1:0] y,
   input  fp_class_e         cls_x,
   input  fp_class_e         cls_y,
   input  logic [1:0]        rm,
   output logic              hit,
   output logic [WORD_W-1:0] value,
   output logic              invalid
);
   localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);
   localparam logic [WORD_W-1:0] DFLT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic xs, ys, x_zero, y_zero, x_inf, y_inf, rm_down;

   assign xs      = x[WORD_W-1];
   assign ys      = y[WORD_W-1];
   assign x_zero  = (cls_x == CL_ZERO);
   assign y_zero  = (cls_y == CL_ZERO);
   assign x_inf   = (cls_x == CL_INF);
   assign y_inf   = (cls_y == CL_INF);
   assign rm_down = (rm == RM_DOWN);

   // Fixed priority: sNaN x, sNaN y, qNaN x, qNaN y, inf pairs, zero pairs.
   always_comb begin
      hit     = 1'b1;
      invalid = 1'b0;
      value   = x;
      if (cls_x == CL_SNAN) begin
         value   = x | QUIET_BIT;
         invalid = 1'b1;
      end else if (cls_y == CL_SNAN) begin
         value   = y | QUIET_BIT;
         invalid = 1'b1;
      end else if (cls_x == CL_QNAN)
         value = x;
      else if (cls_y == CL_QNAN)
         value = y;
      else if (x_inf && y_inf) begin
         if (xs == ys) begin
            value   = DFLT_NAN;
            invalid = 1'b1;
         end
      end else if (y_inf)
         value = {~ys, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else if (x_inf)
         value = x;
      else if (x_zero && y_zero) begin
         if (xs == ys)
            value = {rm_down, {(WORD_W-1){1'b0}}};
      end else if (x_zero)
         value = {~ys, y[WORD_W-2:0]};
      else if (y_zero)
         value = x;
      else
         hit = 1'b0;
   end
endmodule

// File: rtl/fp_sub_core.sv
module fp_sub_core
   import fp_sub_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int EXT_W  = SIG_W + 3,
   localparam int EW     = EXP_W + 2
) (
   input  logic [WORD_W-1:0] x,
   input  logic [WORD_W-1:0] y,
   input  logic [1:0]        rm,
   output logic [WORD_W-1:0] value,
   output logic              overflow,
   output logic              underflow,
   output logic              inexact
);
   localparam logic [EW-1:0] EXT_LIM = EW'(EXT_W);
   localparam logic [EW-1:0] EXP_TOP = EW'((1 << EXP_W) - 1);
   localparam logic [EW-1:0] ONE_E   = EW'(1);

   logic              b_s, s_s, same, rnd_up, zero_diff;
   logic [EXP_W-1:0]  b_ex, s_ex;
   logic [FRAC_W-1:0] b_fr, s_fr;
   logic [EW-1:0]     b_e, s_e, diff_e, e, lz, shamt;
   logic [EXT_W-1:0]  b_m, s_m, s_al, m;
   logic [EXT_W:0]    sum;
   logic [SIG_W:0]    mant;
   logic              found;

   always_comb begin
      // y sign inverted: x - y computed as x + (-y); order by magnitude
      if (x[WORD_W-2:0] >= y[WORD_W-2:0]) begin
         b_s = x[WORD_W-1];  b_ex = x[FRAC_W +: EXP_W]; b_fr = x[FRAC_W-1:0];
         s_s = ~y[WORD_W-1]; s_ex = y[FRAC_W +: EXP_W]; s_fr = y[FRAC_W-1:0];
      end else begin
         b_s = ~y[WORD_W-1]; b_ex = y[FRAC_W +: EXP_W]; b_fr = y[FRAC_W-1:0];
         s_s = x[WORD_W-1];  s_ex = x[FRAC_W +: EXP_W]; s_fr = x[FRAC_W-1:0];
      end
      // denormals take the smallest normal exponent, no hidden bit
      b_e = (b_ex == '0) ? ONE_E : EW'(b_ex);
      s_e = (s_ex == '0) ? ONE_E : EW'(s_ex);
      b_m = {(b_ex != '0), b_fr, 3'b000};
      s_m = {(s_ex != '0), s_fr, 3'b000};

      // align with sticky collection
      diff_e = b_e - s_e;
      if (diff_e >= EXT_LIM)
         s_al = {{(EXT_W-1){1'b0}}, (s_m != '0)};
      else
         s_al = (s_m >> diff_e) |
                {{(EXT_W-1){1'b0}}, ((s_m & ~({EXT_W{1'b1}} << diff_e)) != '0)};

      same = (b_s == s_s);
      sum  = '0;
      e    = b_e;
      if (same) begin
         sum = {1'b0, b_m} + {1'b0, s_al};
         if (sum[EXT_W]) begin
            m = sum[EXT_W:1] | {{(EXT_W-1){1'b0}}, sum[0]};
            e = b_e + ONE_E;
         end else
            m = sum[EXT_W-1:0];
      end else
         m = b_m - s_al;
      zero_diff = (m == '0);

      // normalise, never below the smallest normal exponent
      lz    = '0;
      found = 1'b0;
      for (int i = EXT_W - 1; i >= 0; i--) begin
         if (!found && m[i]) found = 1'b1;
         else if (!found) lz = lz + ONE_E;
      end
      shamt = (lz < (e - ONE_E)) ? lz : (e - ONE_E);
      m     = m << shamt;
      e     = e - shamt;
      underflow = 1'b0;

      // rounding on guard/round/sticky
      inexact = (m[2:0] != 3'b000);
      unique case (rnd_mode_e'(rm))
         RM_NEAREST: rnd_up = m[2] & (m[1] | m[0] | m[3]);
         RM_ZERO:    rnd_up = 1'b0;
         RM_UP:      rnd_up = inexact & ~b_s;
         default:    rnd_up = inexact & b_s;
      endcase
      underflow = ~m[EXT_W-1] & inexact;
      mant = {1'b0, m[EXT_W-1:3]} + {{SIG_W{1'b0}}, rnd_up};
      if (mant[SIG_W]) begin
         mant = mant >> 1;
         e    = e + ONE_E;
      end

      overflow = 1'b0;
      if (zero_diff) begin
         value     = {(rm == RM_DOWN), {(WORD_W-1){1'b0}}};
         inexact   = 1'b0;
         underflow = 1'b0;
      end else if (e >= EXP_TOP) begin
         overflow = 1'b1;
         inexact  = 1'b1;
         if (rm == RM_NEAREST || (rm == RM_UP && !b_s) || (rm == RM_DOWN && b_s))
            value = {b_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         else
            value = {b_s, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end else
         value = {b_s, (mant[SIG_W-1] ? e[EXP_W-1:0] : {EXP_W{1'b0}}), mant[FRAC_W-1:0]};
   end
endmodule

// File: rtl/fp_sub_unit.sv
module fp_sub_unit
   import fp_sub_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter bit REGISTERED = 1'b1,
   localparam int WORD_W    = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] op_x,
   input  logic [WORD_W-1:0] op_y,
   input  logic [1:0]        rnd_mode,
   output logic              out_valid,
   output logic [WORD_W-1:0] result,
   output logic              flag_invalid,
   output logic              flag_overflow,
   output logic              flag_underflow,
   output logic              flag_inexact
);
   if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
      $error("fp_sub_unit: EXP_W out of range");
   end
   if (FRAC_W < 2 || FRAC_W > 112) begin : g_bad_frac
      $error("fp_sub_unit: FRAC_W out of range");
   end

   logic [WORD_W-1:0] ops [2];
   fp_class_e         cls [2];
   logic              sp_hit, sp_inv, c_ovf, c_unf, c_inx;
   logic [WORD_W-1:0] sp_val, c_val, nxt_res;
   fp_flags_t         nxt_flg;

   assign ops[0] = op_x;
   assign ops[1] = op_y;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fp_sub_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
         .word (ops[k]),
         .cls  (cls[k])
      );
   end

   fp_sub_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_special (
      .x       (op_x),
      .y       (op_y),
      .cls_x   (cls[0]),
      .cls_y   (cls[1]),
      .rm      (rnd_mode),
      .hit     (sp_hit),
      .value   (sp_val),
      .invalid (sp_inv)
   );

   fp_sub_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_core (
      .x         (op_x),
      .y         (op_y),
      .rm        (rnd_mode),
      .value     (c_val),
      .overflow  (c_ovf),
      .underflow (c_unf),
      .inexact   (c_inx)
   );

   assign nxt_res = sp_hit ? sp_val : c_val;
   assign nxt_flg = sp_hit ? '{invalid: sp_inv, overflow: 1'b0, underflow: 1'b0, inexact: 1'b0}
                           : '{invalid: 1'b0, overflow: c_ovf, underflow: c_unf, inexact: c_inx};

   if (REGISTERED) begin : g_reg
      fp_flags_t flg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flg_q     <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result <= nxt_res;
               flg_q  <= nxt_flg;
            end
         end
      end

      assign flag_invalid   = flg_q.invalid;
      assign flag_overflow  = flg_q.overflow;
      assign flag_underflow = flg_q.underflow;
      assign flag_inexact   = flg_q.inexact;

      // R13
      vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R13
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(result)));
      // R11
      ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flag_overflow |-> (flag_inexact && result[WORD_W-2:FRAC_W+1] == '1));
      // R12
      unf_denorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flag_underflow |-> (flag_inexact && result[WORD_W-2:FRAC_W] == '0));
      // R1
      inv_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flag_invalid |-> (result[WORD_W-2:FRAC_W] == '1 && result[FRAC_W-1]
                           && !flag_overflow && !flag_inexact));
      // R3
      qnan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_x[WORD_W-2:FRAC_W-1] == '1
          && !(op_y[WORD_W-2:FRAC_W] == '1 && !op_y[FRAC_W-1] && op_y[FRAC_W-2:0] != '0))
         |=> (result == $past(op_x) && !flag_invalid));
   end else begin : g_comb
      assign out_valid      = in_valid;
      assign result         = nxt_res;
      assign flag_invalid   = nxt_flg.invalid;
      assign flag_overflow  = nxt_flg.overflow;
      assign flag_underflow = nxt_flg.underflow;
      assign flag_inexact   = nxt_flg.inexact;
   end
endmodule

// File: tb/test_fp_sub_unit.sv
`timescale 1ns/1ps
module test_fp_sub_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_x = '0, op_y = '0;
   logic [1:0]  rnd_mode = 2'b00;
   logic        out_valid;
   logic [31:0] result;
   logic        f_inv, f_ovf, f_unf, f_inx;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   fp_sub_unit i_fp_sub_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_x(op_x), .op_y(op_y), .rnd_mode(rnd_mode),
      .out_valid(out_valid), .result(result),
      .flag_invalid(f_inv), .flag_overflow(f_ovf),
      .flag_underflow(f_unf), .flag_inexact(f_inx)
   );

   // flags packed as {invalid, overflow, underflow, inexact}
   task automatic run(input string tag, input logic [31:0] x, input logic [31:0] y,
                      input logic [1:0] rm, input logic [31:0] exp_r, input logic [3:0] exp_f);
      @(negedge clk);
      op_x = x; op_y = y; rnd_mode = rm; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (result !== exp_r || {f_inv, f_ovf, f_unf, f_inx} !== exp_f || out_valid !== 1'b1) begin
         errors++;
         $display("FAIL %s: result %h flags %b vld %b, expected %h flags %b vld 1",
                  tag, result, {f_inv, f_ovf, f_unf, f_inx}, out_valid, exp_r, exp_f);
      end
   endtask

   task automatic t_reset();
      checks++;
      if (out_valid !== 1'b0 || result !== 32'h0 || {f_inv, f_ovf, f_unf, f_inx} !== 4'b0) begin
         errors++;
         $display("FAIL R13 reset: vld %b result %h flags %b, expected 0 0 0000",
                  out_valid, result, {f_inv, f_ovf, f_unf, f_inx});
      end
   endtask

   task automatic t_snan();
      run("R1 sNaN x, qNaN y", 32'h7F800001, 32'hFFC00005, 2'b00, 32'h7FC00001, 4'b1000);
      run("R1 both sNaN",      32'hFF800002, 32'h7F800003, 2'b00, 32'hFFC00002, 4'b1000);
      run("R2 qNaN x, sNaN y", 32'h7FC00007, 32'h7FA00000, 2'b00, 32'h7FE00000, 4'b1000);
      run("R2 finite x, sNaN y", 32'h3F800000, 32'hFF800010, 2'b00, 32'hFFC00010, 4'b1000);
   endtask

   task automatic t_qnan();
      run("R3 qNaN x",           32'h7FC00007, 32'h3F800000, 2'b00, 32'h7FC00007, 4'b0000);
      run("R3 inf x, qNaN y",    32'h7F800000, 32'hFFC00009, 2'b00, 32'hFFC00009, 4'b0000);
   endtask

   task automatic t_inf();
      run("R4 inf-inf same",     32'h7F800000, 32'h7F800000, 2'b00, 32'h7FC00000, 4'b1000);
      run("R4 inf-inf differ",   32'h7F800000, 32'hFF800000, 2'b00, 32'h7F800000, 4'b0000);
      run("R5 finite-inf",       32'h3F800000, 32'h7F800000, 2'b00, 32'hFF800000, 4'b0000);
      run("R5 inf-finite",       32'hFF800000, 32'h40400000, 2'b00, 32'hFF800000, 4'b0000);
   endtask

   task automatic t_zero();
      run("R6 +0 - -0",          32'h00000000, 32'h80000000, 2'b11, 32'h00000000, 4'b0000);
      run("R6 -0 - +0",          32'h80000000, 32'h00000000, 2'b00, 32'h80000000, 4'b0000);
      run("R6 +0 - +0 RNE",      32'h00000000, 32'h00000000, 2'b00, 32'h00000000, 4'b0000);
      run("R6 +0 - +0 RDN",      32'h00000000, 32'h00000000, 2'b11, 32'h80000000, 4'b0000);
      run("R7 0 - 1.5",          32'h00000000, 32'h3FC00000, 2'b00, 32'hBFC00000, 4'b0000);
      run("R7 2.5 - 0",          32'h40200000, 32'h80000000, 2'b10, 32'h40200000, 4'b0000);
   endtask

   task automatic t_arith();
      run("R8 3-1",              32'h40400000, 32'h3F800000, 2'b00, 32'h40000000, 4'b0000);
      run("R8 1-3",              32'h3F800000, 32'h40400000, 2'b00, 32'hC0000000, 4'b0000);
      run("R8 1-(-1) carry",     32'h3F800000, 32'hBF800000, 2'b00, 32'h40000000, 4'b0000);
      run("R8 1-2^-24 exact",    32'h3F800000, 32'h33800000, 2'b00, 32'h3F7FFFFF, 4'b0000);
      run("R8 denorm-denorm",    32'h00000003, 32'h00000001, 2'b00, 32'h00000002, 4'b0000);
      run("R9 1-1 RNE",          32'h3F800000, 32'h3F800000, 2'b00, 32'h00000000, 4'b0000);
      run("R9 1-1 RDN",          32'h3F800000, 32'h3F800000, 2'b11, 32'h80000000, 4'b0000);
   endtask

   task automatic t_round();
      run("R10 RNE small",       32'h3F800000, 32'hB3000000, 2'b00, 32'h3F800000, 4'b0001);
      run("R10 RUP small",       32'h3F800000, 32'hB3000000, 2'b10, 32'h3F800001, 4'b0001);
      run("R10 RTZ small",       32'h3F800000, 32'hB3000000, 2'b01, 32'h3F800000, 4'b0001);
      run("R10 tie even down",   32'h3F800000, 32'hB3800000, 2'b00, 32'h3F800000, 4'b0001);
      run("R10 tie odd carry",   32'h3F7FFFFF, 32'hB3000000, 2'b00, 32'h3F800000, 4'b0001);
      run("R10 RDN negative",    32'hBF800000, 32'h33000000, 2'b11, 32'hBF800001, 4'b0001);
      run("R10 RUP negative",    32'hBF800000, 32'h33000000, 2'b10, 32'hBF800000, 4'b0001);
   endtask

   task automatic t_ovf();
      run("R11 ovf RNE",         32'h7F7FFFFF, 32'hFF7FFFFF, 2'b00, 32'h7F800000, 4'b0101);
      run("R11 ovf RTZ",         32'h7F7FFFFF, 32'hFF7FFFFF, 2'b01, 32'h7F7FFFFF, 4'b0101);
      run("R11 neg ovf RUP",     32'hFF7FFFFF, 32'h7F7FFFFF, 2'b10, 32'hFF7FFFFF, 4'b0101);
      run("R11 neg ovf RDN",     32'hFF7FFFFF, 32'h7F7FFFFF, 2'b11, 32'hFF800000, 4'b0101);
   endtask

   task automatic t_tiny();
      run("R12 tiny exact",      32'h00800000, 32'h00000001, 2'b00, 32'h007FFFFF, 4'b0000);
      run("R12 denorm+denorm",   32'h00400000, 32'h80400000, 2'b00, 32'h00800000, 4'b0000);
   endtask

   task automatic t_hold();
      logic [31:0] held;
      run("R13 load", 32'h40400000, 32'h3F800000, 2'b00, 32'h40000000, 4'b0000);
      held = result;
      @(negedge clk);
      op_x = 32'h7F800001; op_y = 32'h7F800000; rnd_mode = 2'b11;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== held || {f_inv, f_ovf, f_unf, f_inx} !== 4'b0) begin
         errors++;
         $display("FAIL R13 hold: vld %b result %h flags %b, expected 0 %h 0000",
                  out_valid, result, {f_inv, f_ovf, f_unf, f_inx}, held);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #5;
      t_reset();
      rst_n = 1'b1;
      t_snan();
      t_qnan();
      t_inf();
      t_zero();
      t_arith();
      t_round();
      t_ovf();
      t_tiny();
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule